// File: doc/BRIEF.md
# Dual-Clock Look-Ahead FIFO

This block carries 36-bit words from a producer in one clock domain to a consumer in a second, unrelated clock domain. Words are kept in a small register-array store. The oldest stored word is moved on its own into an output register on the read side, with no request needed. The consumer therefore sees the head word and its valid flag together, and taking a word is a single handshake.

Both sides use valid/ready streams. On the write side a word is accepted on a write-clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the producer may hold `wr_valid` high, and those attempts leave no trace. On the read side a word is taken on a read-clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the output word and the flag hold steady. Each pointer crosses to the other domain in Gray code through a two-flop synchroniser. Because of this the flags can only be pessimistic: each one reacts a fixed number of edges after the event on the far side. `DEPTH` must be a power of two and at least 4. Each side has its own asynchronous active-low reset, and the two resets are expected to be applied together.

Top module: `xfifo_fwft`

## Requirements
- R1: While reset is applied, `rd_valid` and `wr_ready` are low. `wr_ready` rises within two write-clock edges after reset is released, and `rd_valid` stays low until a word has been written.
- R2: A write attempt made while `wr_ready` is low is discarded: the word is never delivered, and the count of words that can later be read is unchanged.
- R3: The store holds `DEPTH` words in addition to the output register. With the consumer stalled and the output register occupied, exactly `DEPTH` further writes are accepted, and `wr_ready` is then low.
- R4: Every accepted word is delivered on `rd_data` exactly once, in the order written, and never before it has been accepted.
- R5: A word written into an empty FIFO makes `rd_valid` rise no earlier than the third read-clock rising edge after the write edge. In the bench's clocking, where no read edge falls within the synchroniser's skew window, it rises no later than the fourth.
- R6: When a word leaves a full store, `wr_ready` rises no earlier than the second write-clock rising edge after that read edge, and no later than the third.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` stays unchanged.
- R8: When a word is taken and the store holds no word visible to the read side, `rd_valid` goes low on that edge and `rd_data` keeps the word just taken.
- R9: With `rd_ready` held high and synchronised words waiting in the store, a new word is presented on every read-clock cycle. A full FIFO of `DEPTH` words drains in `DEPTH` consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DW (36) | Word offered by the producer |
| wr_ready | output | 1 | Store has a free location; write is taken on valid and ready |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_data | output | DW (36) | Head word held in the output register |
| rd_valid | output | 1 | Output register holds a word not yet taken |

## Verification
The functions most likely to collide are the output-register reload, which takes the last visible stored word, and the synchronised arrival of a newly written word. Two other functions can also land on the same read edge: the stall hold and a pointer update crossing in. To provoke these collisions, the bench runs two independent traffic threads on clocks of 5 ns and 7 ns with a fractional phase offset, using random gaps on both sides and long consumer stalls. This pushes the store repeatedly through its empty and full boundaries. On every read-clock cycle a queue model judges the result: each presented word must equal the queue head, and every handshake must pop exactly one entry.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  // Occupancy seen by the read side, from the synchronised write pointer.
  typedef enum logic [1:0] {
    LVL_EMPTY = 2'd0,
    LVL_ONE   = 2'd1,
    LVL_TWO   = 2'd2,
    LVL_MORE  = 2'd3
  } rd_level_e;

  // Free room seen by the write side, from the synchronised read pointer.
  typedef enum logic [1:0] {
    ROOM_NONE = 2'd0,
    ROOM_ONE  = 2'd1,
    ROOM_TWO  = 2'd2,
    ROOM_MORE = 2'd3
  } wr_room_e;
endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xfifo_mem.sv
`timescale 1ns/1ps
module xfifo_mem #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] cells [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/xfifo_wr_side.sv
`timescale 1ns/1ps
module xfifo_wr_side
  import xfifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] USED_FULL = PW'(DEPTH);
  localparam logic [PW-1:0] USED_FM1  = PW'(DEPTH - 1);
  localparam logic [PW-1:0] USED_FM2  = PW'(DEPTH - 2);

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, used;
  logic          live, accept;
  wr_room_e      room;

  // Gray to binary: each bit is the parity of the gray bits at and above it.
  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign used = wbin - rbin_s;

  always_comb begin
    if (used == USED_FULL)     room = ROOM_NONE;
    else if (used == USED_FM1) room = ROOM_ONE;
    else if (used == USED_FM2) room = ROOM_TWO;
    else                       room = ROOM_MORE;
  end

  assign push_ready = live && (room != ROOM_NONE);
  assign accept     = push_valid && push_ready;
  assign wbin_nxt   = wbin + PW'(1);
  assign mem_we     = accept;
  assign mem_waddr  = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      wbin  <= '0;
      wgray <= '0;
    end else begin
      live <= 1'b1;
      if (accept) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end
  end

  // R2
  wr_reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> $stable(wbin));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= USED_FULL);

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> (wbin == $past(wbin) + PW'(1)));

  // R4
  wr_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/xfifo_rd_side.sv
`timescale 1ns/1ps
module xfifo_rd_side
  import xfifo_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] AVAIL_MAX = PW'(DEPTH);

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, avail;
  logic          load;
  rd_level_e     lvl;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign avail = wbin_s - rbin;

  always_comb begin
    if (avail == '0)              lvl = LVL_EMPTY;
    else if (avail == PW'(1))     lvl = LVL_ONE;
    else if (avail == PW'(2))     lvl = LVL_TWO;
    else                          lvl = LVL_MORE;
  end

  // The register takes a word when it is free or being emptied this edge.
  assign load      = (!out_valid || pop_ready) && (lvl != LVL_EMPTY);
  assign rbin_nxt  = rbin + PW'(1);
  assign mem_raddr = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_data  <= mem_rdata;
      out_valid <= 1'b1;
      rbin      <= rbin_nxt;
      rgray     <= rbin_nxt ^ (rbin_nxt >> 1);
    end else if (pop_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));

  // R7
  stall_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> $stable(rbin));

  // R8
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || $stable(out_data)));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= AVAIL_MAX);

  // R4
  rd_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/xfifo_fwft.sv
`timescale 1ns/1ps
module xfifo_fwft #(
  parameter int DW    = 36,
  parameter int DEPTH = 16
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_rdata;

  xfifo_wr_side #(.AW(AW)) u_wr (
    .clk        (wr_clk),
    .rst_n      (wr_rst_n),
    .push_valid (wr_valid),
    .push_ready (wr_ready),
    .rgray_s    (rgray_s),
    .wgray      (wgray),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr)
  );

  xfifo_sync #(.W(PW)) u_sync_r2w (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rgray),
    .q     (rgray_s)
  );

  xfifo_sync #(.W(PW)) u_sync_w2r (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wgray),
    .q     (wgray_s)
  );

  xfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk  (wr_clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  xfifo_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .pop_ready (rd_ready),
    .out_valid (rd_valid),
    .out_data  (rd_data),
    .wgray_s   (wgray_s),
    .rgray     (rgray),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: tb/test_xfifo_fwft.sv
`timescale 1ns/1ps
module test_xfifo_fwft;
  localparam int DW    = 36;
  localparam int DEPTH = 16;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0, n_push = 0, n_pop = 0;
  logic [DW-1:0] model_q[$];
  logic [DW-1:0] last_rd = '0;
  bit finished = 1'b0;

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1.3;
    forever #3.5 rd_clk = ~rd_clk;
  end

  xfifo_fwft #(.DW(DW), .DEPTH(DEPTH)) i_xfifo_fwft (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Reference model: queue of accepted words, compared on every read cycle.
  always @(negedge wr_clk) begin
    if (wr_rst_n && wr_valid && wr_ready) begin
      model_q.push_back(wr_data);
      n_push++;
    end
  end

  always @(negedge rd_clk) begin
    if (rd_rst_n && rd_valid) begin
      if (model_q.size() == 0) begin
        check(1'b0, "R4 word presented with none pending", 64'(rd_data), 64'h0);
      end else begin
        check(rd_data == model_q[0], "R4 order", 64'(rd_data), 64'(model_q[0]));
        if (rd_ready) begin
          last_rd = model_q.pop_front();
          n_pop++;
        end
      end
    end
  end

  // Called at a write posedge + 1 ns.
  task automatic push(input logic [DW-1:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    do @(negedge wr_clk); while (!wr_ready);
    @(posedge wr_clk);
    #1 wr_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    finish_up();
  end

  initial begin
    int lat, acc, cnt, base;

    // R1: reset state
    repeat (3) @(posedge wr_clk);
    #1;
    check(!rd_valid, "R1 rd_valid during reset", 64'(rd_valid), 64'h0);
    check(!wr_ready, "R1 wr_ready during reset", 64'(wr_ready), 64'h0);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    repeat (2) @(posedge wr_clk);
    #1;
    check(wr_ready, "R1 wr_ready after release", 64'(wr_ready), 64'h1);
    check(!rd_valid, "R1 rd_valid idle after release", 64'(rd_valid), 64'h0);

    // R5: fall-through latency of a single word
    @(posedge wr_clk);
    #1;
    wr_valid = 1'b1;
    wr_data  = 36'h0_A5A5_0001;
    @(posedge wr_clk);
    wr_valid <= 1'b0;
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge rd_clk);
      #0.5;
      if (rd_valid) begin
        lat = k;
        break;
      end
    end
    check(lat >= 3 && lat <= 4, "R5 read edges to rd_valid", 64'(lat), 64'd3);

    // R7: stall holds the presented word
    base = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge rd_clk);
      if (!(rd_valid && rd_data == 36'h0_A5A5_0001)) base++;
    end
    check(base == 0, "R7 stall hold", 64'(base), 64'h0);

    // R3 / R2: fill with consumer stalled; refused words carry distinct values
    acc = 0;
    for (int k = 0; k < DEPTH + 6; k++) begin
      @(posedge wr_clk);
      #1;
      wr_valid = 1'b1;
      wr_data  = DW'(32'h100 + k);
      @(negedge wr_clk);
      if (wr_ready) acc++;
    end
    @(posedge wr_clk);
    #1 wr_valid = 1'b0;
    check(acc == DEPTH, "R3 writes accepted behind occupied register", 64'(acc), 64'(DEPTH));
    check(!wr_ready, "R3 wr_ready low when full", 64'(wr_ready), 64'h0);

    // R2: more attempts while full
    wr_valid = 1'b1;
    wr_data  = 36'h0_DEAD_BEEF;
    repeat (10) @(posedge wr_clk);
    #1 wr_valid = 1'b0;
    check(!wr_ready, "R2 still full after refused writes", 64'(wr_ready), 64'h0);

    // R6: freeing latency after one read from full store
    @(posedge rd_clk);
    #1 rd_ready = 1'b1;
    @(posedge rd_clk);
    rd_ready <= 1'b0;
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge wr_clk);
      #0.5;
      if (wr_ready) begin
        lat = k;
        break;
      end
    end
    check(lat >= 2 && lat <= 3, "R6 write edges to wr_ready", 64'(lat), 64'd2);

    // R9 / R2 / R8: continuous drain
    @(posedge rd_clk);
    #1 rd_ready = 1'b1;
    cnt = 0;
    for (int k = 0; k < 4 * DEPTH; k++) begin
      @(negedge rd_clk);
      if (rd_valid) cnt++;
      else break;
    end
    check(cnt == DEPTH, "R9 and R2 consecutive words drained", 64'(cnt), 64'(DEPTH));
    check(!rd_valid, "R8 rd_valid low after last word", 64'(rd_valid), 64'h0);
    check(rd_data == last_rd, "R8 rd_data keeps last word", 64'(rd_data), 64'(last_rd));
    @(posedge rd_clk);
    #1 rd_ready = 1'b0;
    check(model_q.size() == 0, "R2 no refused word stored", 64'(model_q.size()), 64'h0);

    // Concurrent traffic: reload, empty and full edges colliding with arrivals
    base = n_push;
    fork
      begin
        @(posedge wr_clk);
        #1;
        for (int i = 0; i < 600; i++) begin
          repeat ($urandom_range(0, 2)) @(posedge wr_clk);
          #0;
          push(DW'(32'h4000_0000 + i));
        end
      end
      begin
        int cyc;
        cyc = 0;
        while (n_pop < base + 600) begin
          @(posedge rd_clk);
          #1;
          cyc++;
          if ((cyc % 150) < 40) rd_ready = 1'b0;
          else rd_ready = ($urandom_range(0, 3) != 0);
        end
        rd_ready = 1'b0;
      end
    join

    repeat (10) @(posedge rd_clk);
    #1;
    check(n_pop == n_push, "R4 every word delivered once", 64'(n_pop), 64'(n_push));
    check(!rd_valid, "R8 idle after traffic", 64'(rd_valid), 64'h0);
    check(wr_ready, "R3 room after drain", 64'(wr_ready), 64'h1);
    finish_up();
  end
endmodule